// File: doc/BRIEF.md
# Row Pace Sequencer

The row pace sequencer steps the row pointer of a sampled storage array during playback, recording and fast message scanning. A command starts it with an operation code and, optionally, a row to begin at; from then on it paces each row off a sample tick that it divides down from the system clock. It also produces a row clock that stays high for most of every row and drops low for the closing part of it, which lets the rest of the chip see row boundaries.

While it plays or scans, the sequencer compares the current row against eight end-of-message marker positions. The eight marker bits come from storage outside this block, which presents them for the row on `row_ptr`. The sequencer samples them at each eighth of the row. Reaching a marker ends a playback. A scan that reaches a marker stops with the pointer on the row that follows it, which is where the next message begins. Running off the last row ends any operation with a full-memory strobe. A record never looks at markers. Its first row is stretched by one low-time interval, and the row clock stays high through that extra interval.

The row count, the row and low lengths in sample ticks, and the clock-to-sample divider ratio are all parameters. `ROW_TICKS` and `TICK_DIV` must be multiples of eight, and `start_row` must be below `ROWS`.

Top module: `row_pace_seq`

## Requirements
- R1: After reset `busy` is 0, `row_ptr` is 0, `row_clk` is 1 and both event strobes are 0. While `busy` is 0, `row_clk` stays 1.
- R2: `start` begins an operation on the next clock edge. `mode` selects it: 2'b00 or 2'b11 is play, 2'b01 is record and 2'b10 is scan. With `load_addr` at 1, `row_ptr` takes `start_row`. With `load_addr` at 0, the operation continues from the current `row_ptr`.
- R3: In play, and in every record row after the first, a row lasts ROW_TICKS×TICK_DIV clocks. `row_clk` is low for the last LOW_TICKS×TICK_DIV clocks of the row, and `row_ptr` then steps up by one.
- R4: The first row of a record lasts (ROW_TICKS+LOW_TICKS)×TICK_DIV clocks. `row_clk` is low only for its last LOW_TICKS×TICK_DIV clocks.
- R5: In scan, a row lasts TICK_DIV clocks and `row_clk` is low for its last TICK_DIV/8 clocks.
- R6: Marker bit k (0..7) is reached at the end of the (k+1)-th eighth of the row. In play, reaching a set bit ends the operation with a `msg_end` strobe, and `row_ptr` stays on the row that holds the marker.
- R7: In scan, reaching a set marker bit ends the operation with `msg_end`, and `row_ptr` moves to the following row.
- R8: During record the marker bits have no effect. `msg_end` never fires, and the record runs until memory is full.
- R9: When the last row (ROWS-1) ends without a marker, the operation ends with `mem_full`, and `row_ptr` stays at ROWS-1.
- R10: Marker bit 7 of the last row falls in the same cycle as the end of that row. In play the marker wins: `msg_end` fires and `mem_full` does not. In scan there is no following message: `mem_full` fires, `msg_end` does not, and `row_ptr` stays at ROWS-1.
- R11: When `stop` is sampled without `start`, `busy` drops on that edge with no event strobe. `row_ptr` holds and `row_clk` returns high.
- R12: `msg_end` and `mem_full` are one-cycle strobes. They never fire together, and each one appears in the same cycle that `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (one-cycle pulse) |
| stop | input | 1 | Abort the running operation |
| mode | input | 2 | 00/11 play, 01 record, 10 scan |
| load_addr | input | 1 | 1: take `start_row`; 0: continue from current row |
| start_row | input | RW | Row to begin at when `load_addr` is 1 |
| marker_bits | input | 8 | Marker positions of the row on `row_ptr` |
| row_ptr | output | RW | Current row |
| row_clk | output | 1 | Row clock: high for most of the row, low at its end |
| busy | output | 1 | An operation is running |
| msg_end | output | 1 | Strobe: operation ended on a marker |
| mem_full | output | 1 | Strobe: operation ran off the last row |

## Verification
Two functions can fall in one cycle. Marker detection at the eighth segment boundary coincides with the row-end step, and on the last row that step is also the full-memory condition. The bench places a marker on bit 7 of the last row in play and in scan, on bit 7 of a middle row in scan, and with no marker at all. It judges each case by which strobe appears, the exact clock count from the start edge, and the final `row_ptr`. An independent assertion also forbids both strobes in the same cycle.

// File: rtl/row_pace_pkg.sv
package row_pace_pkg;

  typedef enum logic [1:0] {
    OP_PLAY = 2'b00,
    OP_REC  = 2'b01,
    OP_SCAN = 2'b10
  } op_e;

  // Mode pins to operation; the spare code behaves as play.
  function automatic op_e decode_op(input logic [1:0] mode);
    case (mode)
      2'b01:   return OP_REC;
      2'b10:   return OP_SCAN;
      default: return OP_PLAY;
    endcase
  endfunction

  // Length of the current row in timer units (sample ticks, or clocks in scan).
  function automatic int unsigned row_units(input op_e op, input logic first,
                                            input int unsigned row_t,
                                            input int unsigned low_t,
                                            input int unsigned div);
    if (op == OP_SCAN)           return div;
    if (op == OP_REC && first)   return row_t + low_t;
    return row_t;
  endfunction

  // Units at the row's end during which the row clock is low.
  function automatic int unsigned low_units(input op_e op,
                                            input int unsigned low_t,
                                            input int unsigned div);
    if (op == OP_SCAN) return div / 8;
    return low_t;
  endfunction

  // Units in one eighth of a row (one marker segment).
  function automatic int unsigned seg_units(input op_e op,
                                            input int unsigned row_t,
                                            input int unsigned div);
    if (op == OP_SCAN) return div / 8;
    return row_t / 8;
  endfunction

endpackage

// File: rtl/row_pace_tick.sv
module row_pace_tick #(
  parameter int unsigned TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  logic [DW-1:0] div_q;

  assign tick = run && !clr && (div_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)               div_q <= '0;
    else if (clr || !run)     div_q <= '0;
    else if (div_q == LAST)   div_q <= '0;
    else                      div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/row_pace_timer.sv
module row_pace_timer
  import row_pace_pkg::*;
#(
  parameter int unsigned ROW_TICKS = 1600,
  parameter int unsigned LOW_TICKS = 200,
  parameter int unsigned TICK_DIV  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       restart_rec,
  input  logic       unit,
  input  logic       busy,
  input  op_e        op,
  output logic       row_done,
  output logic       seg_hit,
  output logic [2:0] seg_idx,
  output logic       low_phase
);
  localparam int unsigned UNIT_MAX = ROW_TICKS + LOW_TICKS + TICK_DIV;
  localparam int UW = $clog2(UNIT_MAX + 1);

  logic [UW-1:0] cnt_q, seg_cnt_q;
  logic [2:0]    idx_q;
  logic          first_q, segs_over_q;
  logic [UW-1:0] len_u, low_u, seg_u;
  logic          step, seg_end;

  assign len_u = UW'(row_units(op, first_q, ROW_TICKS, LOW_TICKS, TICK_DIV));
  assign low_u = UW'(low_units(op, LOW_TICKS, TICK_DIV));
  assign seg_u = UW'(seg_units(op, ROW_TICKS, TICK_DIV));

  assign step      = busy && unit;
  assign row_done  = step && (cnt_q == len_u - 1'b1);
  assign seg_end   = step && (seg_cnt_q == seg_u - 1'b1) && !segs_over_q;
  assign seg_hit   = seg_end;
  assign seg_idx   = idx_q;
  assign low_phase = busy && (cnt_q >= len_u - low_u);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      seg_cnt_q   <= '0;
      idx_q       <= '0;
      first_q     <= 1'b0;
      segs_over_q <= 1'b0;
    end else if (restart) begin
      cnt_q       <= '0;
      seg_cnt_q   <= '0;
      idx_q       <= '0;
      first_q     <= restart_rec;
      segs_over_q <= 1'b0;
    end else if (step) begin
      if (row_done) begin
        cnt_q       <= '0;
        seg_cnt_q   <= '0;
        idx_q       <= '0;
        first_q     <= 1'b0;
        segs_over_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (seg_end) begin
          seg_cnt_q <= '0;
          if (idx_q == 3'd7) segs_over_q <= 1'b1;
          else               idx_q <= idx_q + 1'b1;
        end else begin
          seg_cnt_q <= seg_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/row_pace_match.sv
module row_pace_match (
  input  logic       seg_hit,
  input  logic [2:0] seg_idx,
  input  logic [7:0] marker_bits,
  output logic       hit
);
  logic [7:0] hit_vec;

  for (genvar k = 0; k < 8; k++) begin : g_pos
    assign hit_vec[k] = seg_hit && (seg_idx == 3'(k)) && marker_bits[k];
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/row_pace_seq.sv
module row_pace_seq
  import row_pace_pkg::*;
#(
  parameter int unsigned ROWS      = 2400,
  parameter int unsigned ROW_TICKS = 1600,
  parameter int unsigned LOW_TICKS = 200,
  parameter int unsigned TICK_DIV  = 128,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [1:0]    mode,
  input  logic          load_addr,
  input  logic [RW-1:0] start_row,
  input  logic [7:0]    marker_bits,
  output logic [RW-1:0] row_ptr,
  output logic          row_clk,
  output logic          busy,
  output logic          msg_end,
  output logic          mem_full
);
  localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);

  op_e        op_q, op_next;
  logic       tick, unit;
  logic       row_done, seg_hit, low_phase, marker_hit;
  logic [2:0] seg_idx;
  logic       marker_evt, on_last;

  assign op_next    = decode_op(mode);
  assign unit       = (op_q == OP_SCAN) ? busy : tick;
  assign on_last    = (row_ptr == LAST_ROW);
  assign marker_evt = busy && marker_hit && (op_q != OP_REC);
  assign row_clk    = !low_phase;

  row_pace_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .run  (busy),
    .tick (tick)
  );

  row_pace_timer #(
    .ROW_TICKS(ROW_TICKS),
    .LOW_TICKS(LOW_TICKS),
    .TICK_DIV (TICK_DIV)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (start),
    .restart_rec(op_next == OP_REC),
    .unit       (unit),
    .busy       (busy),
    .op         (op_q),
    .row_done   (row_done),
    .seg_hit    (seg_hit),
    .seg_idx    (seg_idx),
    .low_phase  (low_phase)
  );

  row_pace_match u_match (
    .seg_hit    (seg_hit),
    .seg_idx    (seg_idx),
    .marker_bits(marker_bits),
    .hit        (marker_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      row_ptr  <= '0;
      op_q     <= OP_PLAY;
      msg_end  <= 1'b0;
      mem_full <= 1'b0;
    end else begin
      msg_end  <= 1'b0;
      mem_full <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        op_q <= op_next;
        if (load_addr) row_ptr <= start_row;
      end else if (stop) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (marker_evt) begin
          busy <= 1'b0;
          if (op_q == OP_SCAN) begin
            if (on_last) mem_full <= 1'b1;
            else begin
              msg_end <= 1'b1;
              row_ptr <= row_ptr + 1'b1;
            end
          end else begin
            msg_end <= 1'b1;
          end
        end else if (row_done) begin
          if (on_last) begin
            busy     <= 1'b0;
            mem_full <= 1'b1;
          end else begin
            row_ptr <= row_ptr + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/row_pace_check.sv
module row_pace_check
  import row_pace_pkg::*;
#(
  parameter int unsigned ROWS = 2400,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic [RW-1:0] row_ptr,
  input logic          row_clk,
  input logic          busy,
  input logic          msg_end,
  input logic          mem_full,
  input op_e           op_q
);
  assert_idle_clk_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> row_clk);

  assert_row_steps_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start)) |->
      (row_ptr == $past(row_ptr) || row_ptr == RW'($past(row_ptr) + 1'b1)));

  assert_no_msg_end_in_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |-> (op_q != OP_REC));

  assert_full_on_last_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_full |-> (row_ptr == RW'(ROWS - 1)));

  assert_stop_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start && busy) |=> (!busy && !msg_end && !mem_full));

  assert_single_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_end && mem_full));

  assert_event_ends_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end || mem_full) |-> (!busy && $past(busy)));

  assert_event_one_cycle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_end || mem_full) |=> (!msg_end && !mem_full));
endmodule

bind row_pace_seq row_pace_check #(.ROWS(ROWS), .RW(RW)) u_check (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .stop    (stop),
  .row_ptr (row_ptr),
  .row_clk (row_clk),
  .busy    (busy),
  .msg_end (msg_end),
  .mem_full(mem_full),
  .op_q    (op_q)
);

// File: tb/row_pace_seq_test.sv
module row_pace_seq_test;
  localparam int unsigned ROWS = 12;
  localparam int unsigned ROW_TICKS = 16;
  localparam int unsigned LOW_TICKS = 2;
  localparam int unsigned TICK_DIV = 8;
  localparam int RW = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic        load;
    logic [3:0]  row;
    logic        mk_en;
    logic [3:0]  mk_row;
    logic [2:0]  mk_bit;
    logic        full;
    logic [15:0] clks;
    logic [3:0]  exp_row;
  } vec_t;

  // Row = 128 clocks (16 ticks of 8), first record row 144, scan row 8.
  localparam vec_t VECS [10] = '{
    '{2'b00, 1'b1, 4'd3,  1'b1, 4'd5,  3'd2, 1'b0, 16'd304,  4'd5},  // R6 play to marker
    '{2'b00, 1'b1, 4'd10, 1'b0, 4'd0,  3'd0, 1'b1, 16'd256,  4'd11}, // R9 play off the end
    '{2'b01, 1'b1, 4'd9,  1'b1, 4'd10, 3'd0, 1'b1, 16'd400,  4'd11}, // R8 R4 record ignores marker
    '{2'b10, 1'b1, 4'd2,  1'b1, 4'd6,  3'd4, 1'b0, 16'd37,   4'd7},  // R7 scan stops after marker
    '{2'b10, 1'b0, 4'd0,  1'b1, 4'd9,  3'd7, 1'b0, 16'd24,   4'd10}, // R2 R7 scan continues, bit 7
    '{2'b10, 1'b1, 4'd11, 1'b1, 4'd11, 3'd7, 1'b1, 16'd8,    4'd11}, // R10 scan last row bit 7
    '{2'b00, 1'b1, 4'd11, 1'b1, 4'd11, 3'd7, 1'b0, 16'd128,  4'd11}, // R10 play last row bit 7
    '{2'b11, 1'b0, 4'd0,  1'b0, 4'd0,  3'd0, 1'b1, 16'd128,  4'd11}, // R2 continue, spare code plays
    '{2'b10, 1'b1, 4'd0,  1'b0, 4'd0,  3'd0, 1'b1, 16'd96,   4'd11}, // R5 R9 scan whole memory
    '{2'b01, 1'b1, 4'd0,  1'b1, 4'd0,  3'd1, 1'b1, 16'd1552, 4'd11}  // R8 R4 full record
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, load_addr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [RW-1:0] start_row = '0;
  logic [7:0] marker_bits;
  logic [RW-1:0] row_ptr;
  logic row_clk, busy, msg_end, mem_full;

  logic mk_en = 1'b0;
  logic [3:0] mk_row = '0;
  logic [2:0] mk_bit = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n = 0;

  // Storage model: marker bits of the row on row_ptr.
  assign marker_bits = (mk_en && row_ptr == mk_row) ? (8'd1 << mk_bit) : 8'd0;

  row_pace_seq #(
    .ROWS(ROWS), .ROW_TICKS(ROW_TICKS), .LOW_TICKS(LOW_TICKS), .TICK_DIV(TICK_DIV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mode(mode),
    .load_addr(load_addr), .start_row(start_row), .marker_bits(marker_bits),
    .row_ptr(row_ptr), .row_clk(row_clk), .busy(busy),
    .msg_end(msg_end), .mem_full(mem_full)
  );

  always #2.5 clk = ~clk;

  task automatic summary_and_end();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 150000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue a start; returns at the negedge after the start edge, n = 0.
  task automatic fire(input logic [1:0] m, input logic ld, input logic [3:0] r);
    @(negedge clk);
    mode = m; load_addr = ld; start_row = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
  endtask

  task automatic step_to(input int target);
    while (n < target) begin
      @(posedge clk);
      n = n + 1;
      @(negedge clk);
    end
  endtask

  task automatic do_stop();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 row_ptr", row_ptr, 0);
    chk("R1 row_clk", row_clk, 1);
    chk("R1 msg_end", msg_end, 0);
    chk("R1 mem_full", mem_full, 0);

    // Table walk
    for (int i = 0; i < 10; i++) begin
      mk_en = VECS[i].mk_en; mk_row = VECS[i].mk_row; mk_bit = VECS[i].mk_bit;
      fire(VECS[i].mode, VECS[i].load, VECS[i].row);
      while (n < 4000 && !(msg_end || mem_full)) begin
        @(posedge clk);
        n = n + 1;
        @(negedge clk);
      end
      chk($sformatf("vec%0d event kind R12 {msg_end,mem_full}", i),
          {msg_end, mem_full}, VECS[i].full ? 2 'b01 : 2'b10);
      chk($sformatf("vec%0d clocks to event R3 R5 R6", i), n, VECS[i].clks);
      chk($sformatf("vec%0d row_ptr R7 R9 R10", i), row_ptr, VECS[i].exp_row);
      chk($sformatf("vec%0d busy falls with event R12", i), busy, 0);
      @(negedge clk);
      chk($sformatf("vec%0d strobe lasts one cycle R12", i), msg_end | mem_full, 0);
    end
    mk_en = 1'b0;

    // R3: play row timing and row clock low window
    fire(2'b00, 1'b1, 4'd0);
    step_to(111); chk("R3 row_clk high before low window", row_clk, 1);
    step_to(112); chk("R3 row_clk low at window start", row_clk, 0);
    step_to(127); chk("R3 row_clk low at row end", row_clk, 0);
    chk("R3 row_ptr before step", row_ptr, 0);
    step_to(128); chk("R3 row_clk high in next row", row_clk, 1);
    chk("R3 row_ptr stepped", row_ptr, 1);
    step_to(130);
    // R11: stop mid-row
    do_stop();
    chk("R11 busy dropped", busy, 0);
    chk("R11 row_clk high", row_clk, 1);
    chk("R11 row_ptr held", row_ptr, 1);
    repeat (300) begin
      @(negedge clk);
      if (msg_end || mem_full || row_ptr != 4'd1) begin
        chk("R11 quiet after stop", {msg_end, mem_full, row_ptr}, {2'b00, 4'd1});
      end
    end
    chk("R11 row_ptr after idle", row_ptr, 1);

    // R4: first record row stretched, high through extra interval
    fire(2'b01, 1'b1, 4'd0);
    step_to(127); chk("R4 row_clk high through extra interval", row_clk, 1);
    step_to(128); chk("R4 row_clk low window", row_clk, 0);
    step_to(143); chk("R4 row_clk low at end", row_clk, 0);
    chk("R4 row_ptr held in first row", row_ptr, 0);
    step_to(144); chk("R4 row_ptr stepped after 144", row_ptr, 1);
    chk("R4 row_clk high again", row_clk, 1);
    step_to(255); chk("R4 second row normal high", row_clk, 1);
    step_to(256); chk("R4 second row normal low", row_clk, 0);
    do_stop();

    // R5: scan row timing
    fire(2'b10, 1'b1, 4'd4);
    step_to(6); chk("R5 row_clk high", row_clk, 1);
    step_to(7); chk("R5 row_clk low last clock", row_clk, 0);
    chk("R5 row_ptr before step", row_ptr, 4);
    step_to(8); chk("R5 row_clk high next row", row_clk, 1);
    chk("R5 row_ptr stepped", row_ptr, 5);
    do_stop();
    chk("R11 scan stop busy", busy, 0);

    summary_and_end();
  end
endmodule